// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers four interrupt sources into one status word and drives a single active-low interrupt line towards the host bus. Two sources are asynchronous guest request pins. Each pin passes through a synchroniser and then an edge detector, so only a rising edge counts as a request. The other two sources are single-cycle pulses from inside the chip. One marks a code report step. The other marks the end of a compression or decompression field.

Each source owns a sticky status bit. The bit records its event whatever the enables say, and it stays set until the host clears it by writing a 1 to it. A control word holds one enable per source and a global line enable. The registered interrupt line goes low while any enabled source is pending and the global enable is on. The host reaches both words through a simple register port with a select, a write strobe, write data and combinational read data. Bus decoding is done outside this block.

Top module: `irq_gather`

## Requirements
- R1: After reset both words read as zero and `irq_n_o` is 1.
- R2: Status word layout (`reg_sel_i`=0): bit 30 is guest pin 1, bit 29 is guest pin 0, bit 28 is the code report step and bit 27 is field done. Bit 31 and bits 26:0 always read as 0.
- R3: A write to the status word clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged, and with no set and no clear a status bit holds its value.
- R4: If a source event and a clear of the same bit arrive on the same clock edge, the bit reads as 1 afterwards.
- R5: On a guest pin, only a rising edge sets the status bit. If the pin is driven high just before clock edge k, the bit reads 1 after edge k+2 and still reads 0 after edge k+1. A pin that stays high does not set the bit again once it has been cleared.
- R6: A one-cycle pulse on `code_step_i` or `field_done_i` that is sampled at clock edge k sets its status bit, and the bit reads 1 after edge k.
- R7: A status bit records its event even while its enable bit is 0.
- R8: Control word layout (`reg_sel_i`=1): bits 30, 29, 28 and 27 enable guest pin 1, guest pin 0, the code step and field done, and bit 24 is the global line enable. All other bits are ignored on write and read as 0.
- R9: `irq_n_o` is registered. It goes to 0 one cycle after a pending bit with its enable set meets the global enable. It goes back to 1 one cycle after the last such bit is cleared.
- R10: While the global enable is 0, `irq_n_o` stays 1 whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guest_pin_i | input | 2 | Asynchronous guest request pins (index 0, 1) |
| code_step_i | input | 1 | One-cycle code report step event |
| field_done_i | input | 1 | One-cycle field/frame done event |
| reg_sel_i | input | 1 | Word select: 0 status, 1 control |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| irq_n_o | output | 1 | Active-low interrupt line |

## Verification
Two functions can meet in one cycle: a source event that sets a status bit, and a host write-1 that clears the same bit. The bench provokes this directly. It pulses `code_step_i` in the same cycle as a status write with bit 28 set, then checks that the bit still reads 1. Random cycles mix pulses, clears and control writes so that the collision recurs. Every cycle is compared with a bench model in which the set takes priority over the clear.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned SRC_LSB  = 27;  // sources occupy bits 30:27
  localparam int unsigned GLOB_BIT = 24;
  // source index inside the 4-bit vector
  localparam int unsigned IDX_FIELD = 0;
  localparam int unsigned IDX_CODE  = 1;
  localparam int unsigned IDX_GUEST = 2;  // guest pins 0,1 at index 2,3
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] st_q, st_d;

  // set has priority over a simultaneous clear
  always_comb begin
    st_d = (st_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] en_i,
  input  logic         glob_i,
  output logic [N-1:0] en_o,
  output logic         glob_o
);
  logic [N-1:0] en_q, en_d;
  logic         glob_q, glob_d;

  always_comb begin
    en_d   = en_q;
    glob_d = glob_q;
    if (load_i) begin
      en_d   = en_i;
      glob_d = glob_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      glob_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      glob_q <= glob_d;
    end
  end

  assign en_o   = en_q;
  assign glob_o = glob_q;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int unsigned NUM_GUEST   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_GUEST-1:0] guest_pin_i,
  input  logic                 code_step_i,
  input  logic                 field_done_i,
  input  logic                 reg_sel_i,
  input  logic                 reg_wr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic                 irq_n_o
);
  localparam int unsigned SRC_MSB = SRC_LSB + NUM_SRC - 1;

  logic [NUM_GUEST-1:0] guest_rise;
  logic [NUM_SRC-1:0]   src_set, src_clr, status_vec, en_vec;
  logic                 glob_en;
  logic                 stat_wr, ctrl_wr;
  logic                 irq_n_q, irq_n_d;
  logic                 unused_wbits;

  for (genvar g = 0; g < NUM_GUEST; g++) begin : g_guest
    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (guest_pin_i[g]),
      .rise_o  (guest_rise[g])
    );
  end

  assign stat_wr = reg_wr_i & ~reg_sel_i;
  assign ctrl_wr = reg_wr_i &  reg_sel_i;

  always_comb begin
    src_set = '0;
    src_set[IDX_FIELD] = field_done_i;
    src_set[IDX_CODE]  = code_step_i;
    for (int g = 0; g < NUM_GUEST; g++) src_set[IDX_GUEST+g] = guest_rise[g];
    src_clr = stat_wr ? reg_wdata_i[SRC_MSB:SRC_LSB] : '0;
  end

  irq_status_reg #(.N(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_set),
    .clr_i    (src_clr),
    .status_o (status_vec)
  );

  irq_ctrl_reg #(.N(NUM_SRC)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ctrl_wr),
    .en_i   (reg_wdata_i[SRC_MSB:SRC_LSB]),
    .glob_i (reg_wdata_i[GLOB_BIT]),
    .en_o   (en_vec),
    .glob_o (glob_en)
  );

  always_comb begin
    irq_n_d = ~((|(status_vec & en_vec)) & glob_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= irq_n_d;
  end

  assign irq_n_o = irq_n_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o[SRC_MSB:SRC_LSB] = en_vec;
      reg_rdata_o[GLOB_BIT]        = glob_en;
    end else begin
      reg_rdata_o[SRC_MSB:SRC_LSB] = status_vec;
    end
  end

  assign unused_wbits = ^{reg_wdata_i[WORD_W-1:SRC_MSB+1],
                          reg_wdata_i[SRC_LSB-1:GLOB_BIT+1],
                          reg_wdata_i[GLOB_BIT-1:0]};
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        code_step_i,
  input logic        field_done_i,
  input logic        reg_sel_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        irq_n_o,
  input logic [3:0]  st,
  input logic [3:0]  en,
  input logic        glob
);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_step_i |=> st[1]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_sel_i && reg_wdata_i[28] && !code_step_i) |=> !st[1]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_done_i && !(reg_wr_i && !reg_sel_i && reg_wdata_i[27])) |=> (st[0] == $past(st[0])));

  p_stat_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel_i |-> (reg_rdata_o[26:0] == 27'd0 && !reg_rdata_o[31]));

  p_ctrl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel_i |-> (reg_rdata_o[23:0] == 24'd0 && reg_rdata_o[26:25] == 2'd0 && !reg_rdata_o[31]));

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(st & en)) && glob) |=> !irq_n_o);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(st & en)) && glob) |=> irq_n_o);

  p_no_glob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !glob |=> irq_n_o);
endmodule

bind irq_gather irq_gather_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .code_step_i  (code_step_i),
  .field_done_i (field_done_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_n_o      (irq_n_o),
  .st           (status_vec),
  .en           (en_vec),
  .glob         (glob_en)
);

// File: tb/irq_gather_test.sv
`timescale 1ns/1ps
module irq_gather_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  guest_pin_i;
  logic        code_step_i, field_done_i, reg_sel_i, reg_wr_i;
  logic [31:0] reg_wdata_i, reg_rdata_o;
  logic        irq_n_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model
  logic [3:0] es;   // status: 0 field, 1 code, 2 guest0, 3 guest1
  logic [3:0] een;
  logic       eg;
  logic       eirq_n;

  always #2 clk = ~clk;

  irq_gather uut (
    .clk(clk), .rst_n(rst_n), .guest_pin_i(guest_pin_i),
    .code_step_i(code_step_i), .field_done_i(field_done_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  function automatic logic [31:0] exp_word(input logic sel);
    if (sel) return {1'b0, een, 2'b00, eg, 24'd0};
    else     return {1'b0, es, 27'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check after edge
  task automatic step(input string tag, input logic cs, input logic fd,
                      input logic wr, input logic sel, input logic [31:0] wd,
                      input logic [1:0] gp, input logic [3:0] extra);
    logic       nirq;
    logic [3:0] clr;
    @(negedge clk);
    code_step_i = cs; field_done_i = fd; reg_wr_i = wr;
    reg_sel_i = sel; reg_wdata_i = wd; guest_pin_i = gp;
    @(posedge clk);
    nirq = !((|(es & een)) && eg);
    clr  = (wr && !sel) ? wd[30:27] : 4'd0;
    es   = (es & ~clr) | extra | {2'b00, cs, fd};
    if (wr && sel) begin een = wd[30:27]; eg = wd[24]; end
    eirq_n = nirq;
    #1;
    chk({tag, " rdata"}, reg_rdata_o, exp_word(sel));
    chk({tag, " irq_n"}, {31'd0, irq_n_o}, {31'd0, eirq_n});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    es = '0; een = '0; eg = 1'b0; eirq_n = 1'b1;
    rst_n = 1'b0; guest_pin_i = '0; code_step_i = 0; field_done_i = 0;
    reg_sel_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", reg_rdata_o, 32'd0);
    chk("R1 irq_n", {31'd0, irq_n_o}, 32'd1);
    reg_sel_i = 1; #1;
    chk("R1 control", reg_rdata_o, 32'd0);

    // R6 R7 field pulse with enables off
    step("R6 R7 field pulse", 0, 1, 0, 0, '0, 2'b00, 4'b0000);
    chk("R6 bit27", reg_rdata_o, 32'h0800_0000);
    // R3 writing zeros leaves status alone
    step("R3 write zero", 0, 0, 1, 0, 32'h0000_0000, 2'b00, 4'b0000);
    chk("R3 zero no effect", reg_rdata_o, 32'h0800_0000);
    step("R3 clear bit27", 0, 0, 1, 0, 32'h0800_0000, 2'b00, 4'b0000);
    chk("R3 cleared", reg_rdata_o, 32'd0);
    // R4 collision: code pulse with clear of bit 28
    step("R4 collide", 1, 0, 1, 0, 32'h1000_0000, 2'b00, 4'b0000);
    chk("R4 set wins", reg_rdata_o, 32'h1000_0000);
    // R8 control layout
    step("R8 ctrl all", 0, 0, 1, 1, 32'hFFFF_FFFF, 2'b00, 4'b0000);
    chk("R8 readback", reg_rdata_o, 32'h7900_0000);
    // R10 global off: code enabled and pending, line stays high
    step("R10 glob off", 0, 0, 1, 1, 32'h1000_0000, 2'b00, 4'b0000);
    step("R10 hold", 0, 0, 0, 1, '0, 2'b00, 4'b0000);
    chk("R10 irq high", {31'd0, irq_n_o}, 32'd1);
    // R9 turn on global: line low one cycle later
    step("R9 glob on", 0, 0, 1, 1, 32'h1100_0000, 2'b00, 4'b0000);
    chk("R9 not yet", {31'd0, irq_n_o}, 32'd1);
    step("R9 asserted", 0, 0, 0, 0, '0, 2'b00, 4'b0000);
    chk("R9 low", {31'd0, irq_n_o}, 32'd0);
    step("R9 clear", 0, 0, 1, 0, 32'h1000_0000, 2'b00, 4'b0000);
    chk("R9 still low", {31'd0, irq_n_o}, 32'd0);
    step("R9 release", 0, 0, 0, 0, '0, 2'b00, 4'b0000);
    chk("R9 high", {31'd0, irq_n_o}, 32'd1);

    // R5 guest pin 0 rising edge, R2 bit 29
    step("R5 g0 k", 0, 0, 0, 0, '0, 2'b01, 4'b0000);
    step("R5 g0 k+1", 0, 0, 0, 0, '0, 2'b01, 4'b0000);
    chk("R5 not yet", reg_rdata_o, 32'd0);
    step("R5 g0 k+2", 0, 0, 0, 0, '0, 2'b01, 4'b0100);
    chk("R2 bit29", reg_rdata_o, 32'h2000_0000);
    step("R5 clear g0", 0, 0, 1, 0, 32'h2000_0000, 2'b01, 4'b0000);
    for (int i = 0; i < 4; i++) step("R5 level", 0, 0, 0, 0, '0, 2'b01, 4'b0000);
    chk("R5 level no reset", reg_rdata_o, 32'd0);
    // R2 guest pin 1 at bit 30, R7 recorded while disabled
    step("R2 g1 k", 0, 0, 0, 0, '0, 2'b11, 4'b0000);
    step("R2 g1 k+1", 0, 0, 0, 0, '0, 2'b11, 4'b0000);
    step("R2 g1 k+2", 0, 0, 0, 0, '0, 2'b11, 4'b1000);
    chk("R2 bit30", reg_rdata_o, 32'h4000_0000);
    step("R2 fall", 0, 0, 1, 0, 32'h4000_0000, 2'b00, 4'b0000);
    for (int i = 0; i < 3; i++) step("R2 quiet", 0, 0, 0, 0, '0, 2'b00, 4'b0000);

    // random mix of pulses, clears and control writes
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      logic wr, sel, cs, fd;
      cs  = ($urandom % 4) == 0;
      fd  = ($urandom % 4) == 0;
      wr  = ($urandom % 3) == 0;
      sel = ($urandom % 3) == 0;
      wd  = $urandom;
      step("R3 R4 R9 random", cs, fd, wr, sel, wd, 2'b00, 4'b0000);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule